// File: doc/BRIEF.md
# Byte-Lane Bus Access Sequencer

This block sits between a 16-bit processor core and a memory bus whose data path is split into a low byte lane (bits 7:0) and a high byte lane (bits 15:8). The core asks for a byte or word read or write at a 20-bit byte address. The sequencer runs one or two bus cycles to serve the request and reports completion with a one-clock `done` pulse, with the read data lined up at bit 0.

Lane selection on the bus uses address bit 0 together with an active-low high-lane enable. A byte access uses exactly one lane. A word at an even address moves both lanes in a single cycle. A word at an odd address cannot be moved in one cycle, so it is split into two byte cycles. The first cycle uses the odd byte at the requested address on the high lane. The second cycle uses the following even byte on the low lane. The two bytes are then rejoined into one word.

Every bus cycle is four clocks long: an address clock, two transfer clocks and an end clock. The memory can stretch the cycle by holding `bus_ready` low in the second transfer clock. A split word therefore costs exactly four clocks more than an aligned access.

Top module: `bus_lane_sequencer`

## Requirements
- R1: A byte access at an even address runs one bus cycle at that address, with `bus_a0`=0 and `bus_bhe_n`=1. A read returns the low lane (bits 7:0) in `rdata[7:0]`, with `rdata[15:8]`=0.
- R2: A byte access at an odd address runs one bus cycle at that address, with `bus_a0`=1 and `bus_bhe_n`=0. A read returns the high lane (bits 15:8), shifted down into `rdata[7:0]`, with `rdata[15:8]`=0. No bus cycle ever has `bus_a0`=1 and `bus_bhe_n`=1 together.
- R3: A word access at an even address runs a single bus cycle with `bus_a0`=0 and `bus_bhe_n`=0. A read returns the full 16-bit bus word.
- R4: A word access at an odd address A runs two bus cycles. The first is at A with `bus_a0`=1 and `bus_bhe_n`=0. The second is at A+1 with `bus_a0`=0 and `bus_bhe_n`=1. A read returns {low lane of the second cycle, high lane of the first cycle}.
- R5: With `bus_ready` held high, `done` is high in the 4th clock after the accepting edge for a one-cycle access, and in the 8th clock for a split word.
- R6: Each clock in which `bus_ready` is low during the second transfer clock lengthens that bus cycle, and so delays `done`, by one clock.
- R7: On writes, a byte is copied onto both lanes of `bus_dout`. An aligned word drives `req_wdata` unchanged. A split word drives `req_wdata[7:0]` in its first cycle and `req_wdata[15:8]` in its second.
- R8: A request is accepted only at an edge where `req_valid` and `idle` are both high. `req_valid` while busy starts no bus cycle. `done` lasts one clock and is followed by `idle`=1.
- R9: The address of the second half of a split word is A+1 modulo 2^20, so a word at 0xFFFFF uses addresses 0xFFFFF and 0x00000.
- R10: After reset, `idle`=1, `done`=0, `bus_bhe_n`=1, and `bus_ale`, `bus_rd` and `bus_wr` are all 0.
- R11: `bus_ale` is high for the first clock of each bus cycle. `bus_rd` or `bus_wr` is high for the next two clocks plus any wait clocks. The bus address and lane lines stay stable from the address clock into the transfer clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data; a byte uses bits 7:0 |
| idle | output | 1 | Sequencer can accept a request |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read data, valid while `done` is high |
| bus_addr | output | 19 | Bus address bits 19:1 |
| bus_a0 | output | 1 | Bus address bit 0 |
| bus_bhe_n | output | 1 | Active-low high-lane enable |
| bus_ale | output | 1 | Address clock of a bus cycle |
| bus_rd | output | 1 | Read transfer strobe |
| bus_wr | output | 1 | Write transfer strobe |
| bus_dout | output | 16 | Write data lanes |
| bus_din | input | 16 | Read data lanes |
| bus_ready | input | 1 | Memory ready; low stretches the cycle |

## Verification
Two functions can land in the same clock: the `done` pulse of one access, and a new request that the core already holds on `req_valid`. The bench raises a fresh request in the very clock that `done` is seen. It then checks that the next clock is idle with no address strobe, and that the new address clock follows one clock later. It also raises `req_valid` in the middle of a split word and checks that no extra bus cycle and no write strobe appear. Wait clocks on the first half of a split word are used to check that the two-cycle sequence and the extra four clocks simply stack.

// File: rtl/bls_pkg.sv
// Shared types for the byte-lane bus sequencer.
// Assumes a bus with exactly two byte lanes.
package bls_pkg;

    localparam int BLS_ADDR_W = 20;
    localparam int BLS_DATA_W = 16;

    // Phases of a single bus cycle, plus idle
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_XFER1,
        PH_XFER2,
        PH_END
    } bus_phase_e;

    // How captured lane data lands in the returned word
    typedef enum logic [2:0] {
        CAP_LO_BYTE,
        CAP_HI_BYTE,
        CAP_WORD,
        CAP_FIRST_HALF,
        CAP_SECOND_HALF
    } capture_e;

    // Per-bus-cycle lane plan
    typedef struct packed {
        logic     bhe_n;
        capture_e cap;
    } lane_plan_t;

endpackage

// File: rtl/bls_access_plan.sv
// Works out, for the current bus cycle of a latched request, the
// address, the lane enable, the read capture mode and the write lanes.
// Purely combinational; assumes the request is held stable while busy.
module bls_access_plan
    import bls_pkg::*;
#(
    parameter int ADDR_W = BLS_ADDR_W,
    parameter int DATA_W = BLS_DATA_W
) (
    input  logic              req_word,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              second_half,
    output logic              split,
    output logic [ADDR_W-1:0] cyc_addr,
    output lane_plan_t        plan,
    output logic [DATA_W-1:0] cyc_wdata
);
    localparam int HALF  = DATA_W / 2;
    localparam int LANES = DATA_W / HALF;

    logic [HALF-1:0]   wr_byte;
    logic [DATA_W-1:0] wr_rep;

    // A word at an odd address needs two byte cycles
    assign split = req_word & req_addr[0];

    // Second half moves to the next byte, wrapping at the top
    assign cyc_addr = second_half ? (req_addr + ADDR_W'(1)) : req_addr;

    // Lane enable, capture mode and byte to write for this cycle
    always_comb begin
        wr_byte = req_wdata[HALF-1:0];
        if (!req_word) begin
            plan.bhe_n = ~req_addr[0];
            plan.cap   = req_addr[0] ? CAP_HI_BYTE : CAP_LO_BYTE;
        end else if (!req_addr[0]) begin
            plan.bhe_n = 1'b0;
            plan.cap   = CAP_WORD;
        end else if (!second_half) begin
            plan.bhe_n = 1'b0;
            plan.cap   = CAP_FIRST_HALF;
        end else begin
            plan.bhe_n = 1'b1;
            plan.cap   = CAP_SECOND_HALF;
            wr_byte    = req_wdata[DATA_W-1:HALF];
        end
    end

    // Copy the byte to write onto every lane
    for (genvar l = 0; l < LANES; l++) begin : g_rep
        assign wr_rep[l*HALF +: HALF] = wr_byte;
    end

    // An aligned word passes through; everything else uses the copies
    assign cyc_wdata = (plan.cap == CAP_WORD) ? req_wdata : wr_rep;

endmodule

// File: rtl/bls_cycle_fsm.sv
// Steps through the four clocks of each bus cycle and, for a split
// word, through a second cycle. Ready is sampled in the second
// transfer clock only. Done is high in the end clock of the last cycle.
module bls_cycle_fsm
    import bls_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       split,
    input  logic       bus_ready,
    output bus_phase_e phase,
    output logic       second_half,
    output logic       capture,
    output logic       done,
    output logic       idle
);
    // Phase and half-index sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_IDLE;
            second_half <= 1'b0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase       <= PH_ADDR;
                        second_half <= 1'b0;
                    end
                end
                PH_ADDR:  phase <= PH_XFER1;
                PH_XFER1: phase <= PH_XFER2;
                PH_XFER2: if (bus_ready) phase <= PH_END;
                PH_END: begin
                    if (split && !second_half) begin
                        phase       <= PH_ADDR;
                        second_half <= 1'b1;
                    end else begin
                        phase <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // Decoded status of the current clock
    assign capture = (phase == PH_XFER2) && bus_ready;
    assign done    = (phase == PH_END) && (!split || second_half);
    assign idle    = (phase == PH_IDLE);

endmodule

// File: rtl/bls_read_merge.sv
// Captures lane data at the end of each read transfer and lines it up
// into the returned word. The first half of a split word fills the low
// byte; the second half fills the high byte and keeps the first.
module bls_read_merge
    import bls_pkg::*;
#(
    parameter int DATA_W = BLS_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  capture_e          cap,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] rdata
);
    localparam int HALF = DATA_W / 2;

    // Read data register, updated on each capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (capture) begin
            unique case (cap)
                CAP_LO_BYTE:     rdata <= {{HALF{1'b0}}, bus_din[HALF-1:0]};
                CAP_HI_BYTE:     rdata <= {{HALF{1'b0}}, bus_din[DATA_W-1:HALF]};
                CAP_WORD:        rdata <= bus_din;
                CAP_FIRST_HALF:  rdata <= {{HALF{1'b0}}, bus_din[DATA_W-1:HALF]};
                CAP_SECOND_HALF: rdata <= {bus_din[HALF-1:0], rdata[HALF-1:0]};
                default:         rdata <= rdata;
            endcase
        end
    end

endmodule

// File: rtl/bus_lane_sequencer.sv
// Top of the byte-lane bus sequencer. Latches a byte or word request
// when idle, runs one or two four-clock bus cycles with lane enables,
// steers write data onto the lanes, and returns aligned read data with
// a one-clock done pulse. Assumes the core waits for idle to issue.
module bus_lane_sequencer
    import bls_pkg::*;
#(
    parameter int ADDR_W = BLS_ADDR_W,
    parameter int DATA_W = BLS_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              idle,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:1] bus_addr,
    output logic              bus_a0,
    output logic              bus_bhe_n,
    output logic              bus_ale,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_dout,
    input  logic [DATA_W-1:0] bus_din,
    input  logic              bus_ready
);
    logic              start;
    logic              r_write;
    logic              r_word;
    logic [ADDR_W-1:0] r_addr;
    logic [DATA_W-1:0] r_wdata;
    logic              split;
    logic              second_half;
    logic              capture;
    logic              active;
    logic              strobe;
    logic [ADDR_W-1:0] cyc_addr;
    logic [DATA_W-1:0] cyc_wdata;
    lane_plan_t        plan;
    bus_phase_e        phase;

    assign start = req_valid && idle;

    // Latch the request at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_write <= 1'b0;
            r_word  <= 1'b0;
            r_addr  <= '0;
            r_wdata <= '0;
        end else if (start) begin
            r_write <= req_write;
            r_word  <= req_word;
            r_addr  <= req_addr;
            r_wdata <= req_wdata;
        end
    end

    bls_access_plan #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_plan (
        .req_word    (r_word),
        .req_addr    (r_addr),
        .req_wdata   (r_wdata),
        .second_half (second_half),
        .split       (split),
        .cyc_addr    (cyc_addr),
        .plan        (plan),
        .cyc_wdata   (cyc_wdata)
    );

    bls_cycle_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .split       (split),
        .bus_ready   (bus_ready),
        .phase       (phase),
        .second_half (second_half),
        .capture     (capture),
        .done        (done),
        .idle        (idle)
    );

    bls_read_merge #(
        .DATA_W (DATA_W)
    ) u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture && !r_write),
        .cap     (plan.cap),
        .bus_din (bus_din),
        .rdata   (rdata)
    );

    // Bus-side decode of the current phase
    assign active    = (phase != PH_IDLE);
    assign strobe    = (phase == PH_XFER1) || (phase == PH_XFER2);
    assign bus_addr  = active ? cyc_addr[ADDR_W-1:1] : '0;
    assign bus_a0    = active && cyc_addr[0];
    assign bus_bhe_n = active ? plan.bhe_n : 1'b1;
    assign bus_ale   = (phase == PH_ADDR);
    assign bus_rd    = strobe && !r_write;
    assign bus_wr    = strobe && r_write;
    assign bus_dout  = (r_write && (strobe || phase == PH_END)) ? cyc_wdata : '0;

endmodule

// File: rtl/bls_checker.sv
// Protocol checks on the ports of the byte-lane bus sequencer.
module bls_checker #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              idle,
    input logic              done,
    input logic [ADDR_W-1:1] bus_addr,
    input logic              bus_a0,
    input logic              bus_bhe_n,
    input logic              bus_ale,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_dout,
    input logic              bus_ready
);
    localparam int HALF = DATA_W / 2;

    AST_SOME_LANE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> !(bus_a0 && bus_bhe_n)); // R2
    AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> idle); // R8
    AST_ACCEPT_STARTS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && idle) |=> (!idle && bus_ale)); // R8
    AST_ALE_THEN_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> ((bus_rd || bus_wr) && $stable(bus_addr) && $stable(bus_a0)
                     && $stable(bus_bhe_n))); // R11
    AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr)); // R11
    AST_BYTE_WRITE_COPIED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_bhe_n || bus_a0)) |->
            (bus_dout[DATA_W-1:HALF] == bus_dout[HALF-1:0])); // R7
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (bus_bhe_n && !bus_rd && !bus_wr && !bus_ale)); // R10
    AST_WAIT_HOLDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && $past(bus_rd || bus_wr) && !bus_ready) |=>
            (bus_rd || bus_wr)); // R6

endmodule

bind bus_lane_sequencer bls_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .idle      (idle),
    .done      (done),
    .bus_addr  (bus_addr),
    .bus_a0    (bus_a0),
    .bus_bhe_n (bus_bhe_n),
    .bus_ale   (bus_ale),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_dout  (bus_dout),
    .bus_ready (bus_ready)
);

// File: tb/bus_lane_sequencer_tb.sv
// Directed bench for the byte-lane bus sequencer: one task per scenario.
module bus_lane_sequencer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        idle, done;
    logic [15:0] rdata;
    logic [19:1] bus_addr;
    logic        bus_a0, bus_bhe_n, bus_ale, bus_rd, bus_wr;
    logic [15:0] bus_dout;
    logic [15:0] bus_din;
    logic        bus_ready = 1'b1;

    int n_checks = 0;
    int n_fail   = 0;
    int waits_left = 0;
    bit stb_seen = 0;

    // Results of the last access
    int          n_cyc, done_k, first_stb_k, ale_k0;
    logic [19:0] rec_addr [2];
    logic        rec_bhe  [2];
    logic [15:0] rec_dout [2];
    logic [15:0] rd_at_done;
    bit          any_wr, post_ok;

    always #2.5 clk = ~clk;

    bus_lane_sequencer u_dut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid),
        .req_write (req_write), .req_word (req_word), .req_addr (req_addr),
        .req_wdata (req_wdata), .idle (idle), .done (done), .rdata (rdata),
        .bus_addr (bus_addr), .bus_a0 (bus_a0), .bus_bhe_n (bus_bhe_n),
        .bus_ale (bus_ale), .bus_rd (bus_rd), .bus_wr (bus_wr),
        .bus_dout (bus_dout), .bus_din (bus_din), .bus_ready (bus_ready)
    );

    function automatic logic [7:0] mem_byte(input logic [19:0] a);
        return a[7:0] + {a[11:8], a[19:16]} + 8'h3C;
    endfunction

    // Memory model: both lanes of the addressed word
    always_comb bus_din = {mem_byte({bus_addr, 1'b1}), mem_byte({bus_addr, 1'b0})};

    // Ready model: insert waits_left low clocks in the second transfer clock
    always @(negedge clk) begin
        if (bus_rd || bus_wr) begin
            if (stb_seen && waits_left > 0) begin
                bus_ready  <= 1'b0;
                waits_left <= waits_left - 1;
            end else begin
                bus_ready <= 1'b1;
            end
            stb_seen <= 1'b1;
        end else begin
            stb_seen  <= 1'b0;
            bus_ready <= 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issue one request and record what happens on the bus
    task automatic run_access(input bit wr, input bit word, input logic [19:0] a,
                              input logic [15:0] wd, input int waits, input bit poke);
        bit prev_stb = 0;
        @(negedge clk);
        waits_left = waits;
        req_valid = 1; req_write = wr; req_word = word; req_addr = a; req_wdata = wd;
        n_cyc = 0; done_k = 0; first_stb_k = 0; ale_k0 = 0; any_wr = 0;
        rec_dout[0] = '0; rec_dout[1] = '0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (k == 1) req_valid = 0;
            if (poke && k == 2) begin
                req_valid = 1; req_write = 1; req_word = 0; req_addr = 20'h000F0;
            end
            if (poke && k == 3) req_valid = 0;
            if (bus_ale) begin
                if (n_cyc < 2) begin
                    rec_addr[n_cyc] = {bus_addr, bus_a0};
                    rec_bhe[n_cyc]  = bus_bhe_n;
                end
                n_cyc++;
                if (n_cyc == 1) ale_k0 = k;
            end
            if ((bus_rd || bus_wr) && first_stb_k == 0) first_stb_k = k;
            if (bus_wr) any_wr = 1;
            if (bus_wr && !prev_stb && n_cyc >= 1 && n_cyc <= 2)
                rec_dout[n_cyc-1] = bus_dout;
            prev_stb = bus_rd || bus_wr;
            if (done) begin
                done_k = k;
                rd_at_done = rdata;
                break;
            end
        end
        @(negedge clk);
        post_ok = !done && idle;
    endtask

    // Compare a recorded access against the requirement-derived expectation
    task automatic verify(input string req, input bit wr, input bit word,
                          input logic [19:0] a, input logic [15:0] wd, input int waits);
        bit          sp    = word && a[0];
        logic [19:0] a1    = a + 20'd1;
        logic [15:0] exp_r = word ? {mem_byte(a1), mem_byte(a)} : {8'h00, mem_byte(a)};
        int          exp_k = (sp ? 8 : 4) + waits;
        chk(n_cyc == (sp ? 2 : 1), req, "bus cycle count", n_cyc, sp ? 2 : 1);
        chk(rec_addr[0] == a, req, "first cycle address", rec_addr[0], a);
        chk(rec_bhe[0] == (sp ? 1'b0 : !(word || a[0])), req, "first cycle bhe_n",
            rec_bhe[0], sp ? 1'b0 : !(word || a[0]));
        if (sp) begin
            chk(rec_addr[1] == a1, req, "second cycle address", rec_addr[1], a1);
            chk(rec_bhe[1] == 1'b1, req, "second cycle bhe_n", rec_bhe[1], 1);
        end
        chk(ale_k0 == 1 && first_stb_k == 2, "R11", "ale/strobe clocks",
            {ale_k0[15:0], first_stb_k[15:0]}, 32'h0001_0002);
        chk(done_k == exp_k, (waits > 0) ? "R6" : "R5", "done clock", done_k, exp_k);
        chk(post_ok, "R8", "single done then idle", post_ok, 1);
        if (!wr) begin
            chk(rd_at_done == exp_r, req, "read data", rd_at_done, exp_r);
        end else if (!word) begin
            chk(rec_dout[0] == {wd[7:0], wd[7:0]}, "R7", "byte lanes", rec_dout[0],
                {wd[7:0], wd[7:0]});
        end else if (!sp) begin
            chk(rec_dout[0] == wd, "R7", "aligned word lanes", rec_dout[0], wd);
        end else begin
            chk(rec_dout[0] == {wd[7:0], wd[7:0]}, "R7", "split first lanes",
                rec_dout[0], {wd[7:0], wd[7:0]});
            chk(rec_dout[1] == {wd[15:8], wd[15:8]}, "R7", "split second lanes",
                rec_dout[1], {wd[15:8], wd[15:8]});
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(idle && !done && bus_bhe_n && !bus_ale && !bus_rd && !bus_wr, "R10",
            "reset outputs", {idle, done, bus_bhe_n, bus_ale, bus_rd, bus_wr}, 6'b101000);
    endtask

    task automatic t_even_byte;
        run_access(0, 0, 20'h12344, 16'h0, 0, 0); verify("R1", 0, 0, 20'h12344, 16'h0, 0);
        run_access(0, 0, 20'h00000, 16'h0, 0, 0); verify("R1", 0, 0, 20'h00000, 16'h0, 0);
    endtask

    task automatic t_odd_byte;
        run_access(0, 0, 20'h12345, 16'h0, 0, 0); verify("R2", 0, 0, 20'h12345, 16'h0, 0);
        run_access(0, 0, 20'hABCDF, 16'h0, 0, 0); verify("R2", 0, 0, 20'hABCDF, 16'h0, 0);
    endtask

    task automatic t_even_word;
        run_access(0, 1, 20'h12344, 16'h0, 0, 0); verify("R3", 0, 1, 20'h12344, 16'h0, 0);
        run_access(0, 1, 20'h7FFFE, 16'h0, 0, 0); verify("R3", 0, 1, 20'h7FFFE, 16'h0, 0);
    endtask

    task automatic t_odd_word;
        run_access(0, 1, 20'h12345, 16'h0, 0, 0); verify("R4", 0, 1, 20'h12345, 16'h0, 0);
        run_access(0, 1, 20'h0FFFF, 16'h0, 0, 0); verify("R4", 0, 1, 20'h0FFFF, 16'h0, 0);
    endtask

    task automatic t_writes;
        run_access(1, 0, 20'h00200, 16'hBEA5, 0, 0); verify("R7", 1, 0, 20'h00200, 16'hBEA5, 0);
        run_access(1, 0, 20'h00201, 16'hC35A, 0, 0); verify("R7", 1, 0, 20'h00201, 16'hC35A, 0);
        run_access(1, 1, 20'h00202, 16'h1234, 0, 0); verify("R7", 1, 1, 20'h00202, 16'h1234, 0);
        run_access(1, 1, 20'h00203, 16'hA1B2, 0, 0); verify("R7", 1, 1, 20'h00203, 16'hA1B2, 0);
    endtask

    task automatic t_wait_states;
        run_access(0, 1, 20'h40000, 16'h0, 2, 0); verify("R6", 0, 1, 20'h40000, 16'h0, 2);
        run_access(0, 1, 20'h40011, 16'h0, 1, 0); verify("R6", 0, 1, 20'h40011, 16'h0, 1);
    endtask

    task automatic t_busy_ignored;
        run_access(0, 1, 20'h55555, 16'h0, 0, 1);
        chk(!any_wr, "R8", "request while busy caused write", any_wr, 0);
        verify("R8", 0, 1, 20'h55555, 16'h0, 0);
    endtask

    task automatic t_wrap;
        run_access(0, 1, 20'hFFFFF, 16'h0, 0, 0); verify("R9", 0, 1, 20'hFFFFF, 16'h0, 0);
        run_access(1, 1, 20'hFFFFF, 16'h9876, 0, 0); verify("R9", 1, 1, 20'hFFFFF, 16'h9876, 0);
    endtask

    // New request raised in the same clock as done of the previous one
    task automatic t_back_to_back;
        bit seen = 0;
        @(negedge clk);
        req_valid = 1; req_write = 0; req_word = 1; req_addr = 20'h30000;
        @(negedge clk);
        req_valid = 0;
        for (int k = 0; k < 20 && !seen; k++) begin
            @(negedge clk);
            if (done) begin
                seen = 1;
                req_valid = 1; req_word = 0; req_addr = 20'h30123;
            end
        end
        chk(seen, "R8", "first done seen", seen, 1);
        @(negedge clk);
        chk(idle && !bus_ale, "R8", "idle clock after done", {idle, bus_ale}, 2'b10);
        @(negedge clk);
        chk(bus_ale && {bus_addr, bus_a0} == 20'h30123, "R8", "next address clock",
            {bus_ale, bus_addr, bus_a0}, {1'b1, 20'h30123});
        req_valid = 0;
        seen = 0;
        for (int k = 0; k < 20 && !seen; k++) begin
            @(negedge clk);
            if (done) begin
                seen = 1;
                chk(rdata == {8'h00, mem_byte(20'h30123)}, "R2", "chained read data",
                    rdata, {8'h00, mem_byte(20'h30123)});
            end
        end
        chk(seen, "R8", "second done seen", seen, 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        t_reset();
        t_even_byte();
        t_odd_byte();
        t_even_word();
        t_odd_word();
        t_writes();
        t_wait_states();
        t_busy_ignored();
        t_wrap();
        t_back_to_back();
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule